// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of conditional branches. It has two component predictors. The first keeps a short outcome history for each branch address and uses that history to select a 3-bit counter. The second uses the recent outcomes of all branches, held in one global history register, to select a 2-bit counter. A third table of 2-bit chooser counters, indexed by the same global history, decides which of the two guesses is used.

The fetch side gives a PC and receives a taken bit in the same cycle, together with the global history value that was used to form that guess. When a predict is accepted, the global history shifts in the guessed direction straight away. The execute side returns the PC, the real outcome, the saved history and a mispredict flag. All tables learn only at that point. On a mispredict, the global history is rebuilt from the saved value with the real outcome appended.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, `pred_ghist` is 0 and `pred_taken` is 0. Every direction counter starts weakly not-taken (2-bit 01, 3-bit 011). Every per-branch history is 0. Every chooser counter starts at 10, which weakly selects the global guess.
- R2: `pred_taken` is combinational from `pred_pc` and the current state. It equals the MSB of the selected counter. The chooser entry at the current global history selects the global counter when its MSB is 1 and the local counter when its MSB is 0.
- R3: Per-branch history is indexed by PC bits [11:2] and is 10 bits wide. The local counter table is indexed by that history. When a branch resolves, its history entry shifts left and takes the actual outcome into bit 0.
- R4: At resolve, the global counter at index `res_ghist` moves one step toward the actual outcome. So does the local counter at the resolving branch's current history.
- R5: Counters saturate. They never wrap past all-ones or below all-zeros.
- R6: The chooser entry at `res_ghist` is trained only when the local and global guesses for the resolving branch differ. It increments when the global guess was right and decrements when the local guess was right.
- R7: `pred_ghist` shows the global history used for the current guess. An accepted predict (`pred_valid`) shifts `pred_taken` into bit 0 of the history by the next cycle. With no predict and no mispredict, the history holds its value.
- R8: A resolve flagged as mispredicted sets the history to `{res_ghist[10:0], res_taken}` in the next cycle. This takes priority over a predict in the same cycle.
- R9: Table contents change only at a resolve. A predict in the same cycle as a resolve to the same entries sees the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A predict is accepted this cycle |
| pred_pc | input | 32 | Fetch PC of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ghist | output | 12 | Global history used for this guess; must be returned at resolve |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | PC of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_ghist | input | 12 | History value saved at predict time |
| res_mispredict | input | 1 | The earlier guess was wrong; rewind the global history |

## Verification
The assertions assume that `pred_pc`, `res_valid` and `res_mispredict` are free of X after reset. They also assume that the tables change only through a resolve, so a repeated PC and history with no resolve in between must give the same guess. They do not assume that `res_ghist` matches any earlier `pred_ghist`. The stimulus therefore draws resolve histories freely from a small set, which drives chooser disagreements and saturation. It keeps PCs within a few address bits so that branches alias in the history table.

// File: rtl/tp_pkg.sv
package tp_pkg;
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
    parameter int                 IDX_W   = 12,
    parameter int                 CTR_W   = 2,
    parameter logic [CTR_W-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rda_idx,
    output logic [CTR_W-1:0] rda_val,
    input  logic [IDX_W-1:0] rdb_idx,
    output logic [CTR_W-1:0] rdb_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CTR_W-1:0] mem_q [DEPTH];
    logic [CTR_W-1:0] cur, nxt_d;

    assign rda_val = mem_q[rda_idx];
    assign rdb_val = mem_q[rdb_idx];
    assign cur     = mem_q[wr_idx];

    always_comb begin
        nxt_d = cur;
        if (wr_up && (cur != {CTR_W{1'b1}}))
            nxt_d = cur + 1'b1;
        else if (!wr_up && (cur != '0))
            nxt_d = cur - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
        end else if (wr_en) begin
            mem_q[wr_idx] <= nxt_d;
        end
    end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic [HIST_W-1:0] rda_val,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic [HIST_W-1:0] rdb_val,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem_q [DEPTH];
    logic [HIST_W-1:0] nxt_d;

    assign rda_val = mem_q[rda_idx];
    assign rdb_val = mem_q[rdb_idx];

    always_comb begin
        nxt_d = {mem_q[wr_idx][HIST_W-2:0], wr_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= nxt_d;
        end
    end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
    parameter int PC_W     = 32,
    parameter int PC_LSB   = 2,
    parameter int LH_IDX_W = 10,
    parameter int LH_W     = 10,
    parameter int GH_W     = 12,
    parameter int LCTR_W   = 3,
    parameter int GCTR_W   = 2,
    parameter int CH_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pred_valid,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic [GH_W-1:0] pred_ghist,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [GH_W-1:0] res_ghist,
    input  logic            res_mispredict
);
    import tp_pkg::*;

    localparam logic [LCTR_W-1:0] LCTR_RST = {1'b0, {(LCTR_W-1){1'b1}}};
    localparam logic [GCTR_W-1:0] GCTR_RST = {1'b0, {(GCTR_W-1){1'b1}}};
    localparam logic [CH_W-1:0]   CH_RST   = {1'b1, {(CH_W-1){1'b0}}};

    typedef struct packed {
        logic [GH_W-1:0] ghr;
    } state_t;

    state_t st_d, st_q;

    logic [LH_IDX_W-1:0] p_lidx, r_lidx;
    logic [LH_W-1:0]     p_lhist, r_lhist;
    logic [LCTR_W-1:0]   p_lctr, r_lctr;
    logic [GCTR_W-1:0]   p_gctr, r_gctr;
    logic [CH_W-1:0]     p_chctr, r_chctr;
    logic                r_lguess, r_gguess, r_disagree;
    src_e                p_src;

    assign p_lidx = pred_pc[PC_LSB +: LH_IDX_W];
    assign r_lidx = res_pc[PC_LSB +: LH_IDX_W];

    tp_hist_table #(.IDX_W(LH_IDX_W), .HIST_W(LH_W)) u_lht (
        .clk(clk), .rst_n(rst_n),
        .rda_idx(p_lidx), .rda_val(p_lhist),
        .rdb_idx(r_lidx), .rdb_val(r_lhist),
        .wr_en(res_valid), .wr_idx(r_lidx), .wr_bit(res_taken)
    );

    tp_ctr_table #(.IDX_W(LH_W), .CTR_W(LCTR_W), .RST_VAL(LCTR_RST)) u_lpt (
        .clk(clk), .rst_n(rst_n),
        .rda_idx(p_lhist), .rda_val(p_lctr),
        .rdb_idx(r_lhist), .rdb_val(r_lctr),
        .wr_en(res_valid), .wr_idx(r_lhist), .wr_up(res_taken)
    );

    tp_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W), .RST_VAL(GCTR_RST)) u_gpt (
        .clk(clk), .rst_n(rst_n),
        .rda_idx(st_q.ghr), .rda_val(p_gctr),
        .rdb_idx(res_ghist), .rdb_val(r_gctr),
        .wr_en(res_valid), .wr_idx(res_ghist), .wr_up(res_taken)
    );

    assign r_lguess   = r_lctr[LCTR_W-1];
    assign r_gguess   = r_gctr[GCTR_W-1];
    assign r_disagree = r_lguess ^ r_gguess;

    tp_ctr_table #(.IDX_W(GH_W), .CTR_W(CH_W), .RST_VAL(CH_RST)) u_cht (
        .clk(clk), .rst_n(rst_n),
        .rda_idx(st_q.ghr), .rda_val(p_chctr),
        .rdb_idx(res_ghist), .rdb_val(r_chctr),
        .wr_en(res_valid && r_disagree), .wr_idx(res_ghist),
        .wr_up(r_gguess == res_taken)
    );

    assign p_src      = src_e'(p_chctr[CH_W-1]);
    assign pred_taken = (p_src == SRC_GLOBAL) ? p_gctr[GCTR_W-1] : p_lctr[LCTR_W-1];
    assign pred_ghist = st_q.ghr;

    always_comb begin
        st_d = st_q;
        if (res_valid && res_mispredict)
            st_d.ghr = {res_ghist[GH_W-2:0], res_taken};
        else if (pred_valid)
            st_d.ghr = {st_q.ghr[GH_W-2:0], pred_taken};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic unused_bits;
    assign unused_bits = ^{pred_pc, res_pc, r_chctr};
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int PC_W = 32,
    parameter int GH_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pred_valid,
    input logic [PC_W-1:0] pred_pc,
    input logic            pred_taken,
    input logic [GH_W-1:0] pred_ghist,
    input logic            res_valid,
    input logic            res_taken,
    input logic [GH_W-1:0] res_ghist,
    input logic            res_mispredict
);
    AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !(res_valid && res_mispredict)) |=>
        pred_ghist == {$past(pred_ghist[GH_W-2:0]), $past(pred_taken)}); // R7

    AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid && !(res_valid && res_mispredict)) |=> $stable(pred_ghist)); // R7

    AST_GHR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |=>
        pred_ghist == {$past(res_ghist[GH_W-2:0]), $past(res_taken)}); // R8

    AST_NO_TRAIN_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ((pred_pc == $past(pred_pc) && pred_ghist == $past(pred_ghist))
                        -> pred_taken == $past(pred_taken))); // R9

    AST_GUESS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_taken)); // R2
endmodule

bind tournament_predictor tp_checker #(.PC_W(PC_W), .GH_W(GH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_ghist(pred_ghist), .res_valid(res_valid),
    .res_taken(res_taken), .res_ghist(res_ghist), .res_mispredict(res_mispredict)
);

// File: tb/tb_tournament_predictor.sv
`timescale 1ns/1ps
module tb_tournament_predictor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pred_valid;
    logic [31:0] pred_pc;
    logic        pred_taken;
    logic [11:0] pred_ghist;
    logic        res_valid;
    logic [31:0] res_pc;
    logic        res_taken;
    logic [11:0] res_ghist;
    logic        res_mispredict;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    tournament_predictor dut (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_ghist(pred_ghist), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_ghist(res_ghist),
        .res_mispredict(res_mispredict)
    );

    // reference state built from the requirements
    logic [9:0]  m_lht [1024];
    logic [2:0]  m_lpt [1024];
    logic [1:0]  m_gpt [4096];
    logic [1:0]  m_cht [4096];
    logic [11:0] m_ghr;

    function automatic logic [2:0] sat3(input logic [2:0] v, input logic up);
        if (up)  return (v == 3'd7) ? v : v + 3'd1;
        return (v == 3'd0) ? v : v - 3'd1;
    endfunction

    function automatic logic [1:0] sat2(input logic [1:0] v, input logic up);
        if (up)  return (v == 2'd3) ? v : v + 2'd1;
        return (v == 2'd0) ? v : v - 2'd1;
    endfunction

    function automatic logic exp_guess(input logic [31:0] pc);
        logic [9:0] h;
        h = m_lht[pc[11:2]];
        return m_cht[m_ghr][1] ? m_gpt[m_ghr][1] : m_lpt[h][2];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin m_lht[i] = '0; m_lpt[i] = 3'b011; end
        for (int i = 0; i < 4096; i++) begin m_gpt[i] = 2'b01; m_cht[i] = 2'b10; end
        m_ghr = '0;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input logic pv, input logic [31:0] ppc, input logic rv,
                        input logic [31:0] rpc, input logic rt, input logic [11:0] rg,
                        input logic rm, input string req);
        logic g, lg, gg;
        logic [9:0] lh;
        @(negedge clk);
        pred_valid = pv; pred_pc = ppc; res_valid = rv; res_pc = rpc;
        res_taken = rt; res_ghist = rg; res_mispredict = rm;
        #1;
        g = exp_guess(ppc);
        check({req, " guess"}, {31'd0, pred_taken}, {31'd0, g});
        check({req, " ghist"}, {20'd0, pred_ghist}, {20'd0, m_ghr});
        if (rv) begin
            lh = m_lht[rpc[11:2]];
            lg = m_lpt[lh][2];
            gg = m_gpt[rg][1];
            m_lpt[lh] = sat3(m_lpt[lh], rt);
            m_gpt[rg] = sat2(m_gpt[rg], rt);
            if (lg != gg) m_cht[rg] = sat2(m_cht[rg], gg == rt);
            m_lht[rpc[11:2]] = {lh[8:0], rt};
        end
        if (rv && rm)  m_ghr = {rg[10:0], rt};
        else if (pv)   m_ghr = {m_ghr[10:0], g};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        process::self().srandom(32'd1234);
        rst_n = 0; pred_valid = 0; pred_pc = 0; res_valid = 0; res_pc = 0;
        res_taken = 0; res_ghist = 0; res_mispredict = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state seen at the ports
        step(0, 32'h100, 0, 0, 0, 0, 0, "R1");
        check("R1 ghist zero", {20'd0, pred_ghist}, 32'd0);
        check("R1 not taken", {31'd0, pred_taken}, 32'd0);

        // R4 R1: one taken resolve at history 0 flips global guess (chooser favours global)
        step(0, 32'h100, 1, 32'h200, 1, 12'h000, 0, "R4");
        step(0, 32'h100, 0, 0, 0, 0, 0, "R4 R2");
        check("R1 global selected", {31'd0, pred_taken}, 32'd1);

        // R5: saturate at top then one not-taken keeps taken
        for (int i = 0; i < 5; i++) step(0, 32'h100, 1, 32'h200, 1, 12'h000, 0, "R5");
        step(0, 32'h100, 1, 32'h200, 0, 12'h000, 0, "R5");
        step(0, 32'h100, 0, 0, 0, 0, 0, "R5");
        check("R5 sat", {31'd0, pred_taken}, 32'd1);

        // R7: predicts shift guess into history
        step(1, 32'h104, 0, 0, 0, 0, 0, "R7");
        step(1, 32'h108, 0, 0, 0, 0, 0, "R7");
        step(0, 32'h108, 0, 0, 0, 0, 0, "R7");
        step(0, 32'h108, 0, 0, 0, 0, 0, "R7 hold");

        // R8: mispredict restore wins over a same-cycle predict
        step(1, 32'h10C, 1, 32'h300, 1, 12'hABC, 1, "R8");
        step(0, 32'h10C, 0, 0, 0, 0, 0, "R8");
        check("R8 restore", {20'd0, pred_ghist}, 32'h579);

        // R9: predict and resolve same entries in one cycle: old value read
        step(0, 32'h300, 1, 32'h300, 0, 12'h579, 0, "R9");
        step(0, 32'h300, 1, 32'h300, 0, 12'h579, 0, "R9");

        // R3 R6: train local history of one branch and cause disagreements
        for (int i = 0; i < 40; i++)
            step(0, 32'h040, 1, 32'h040, i[0], 12'h007, 0, "R3 R6");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, b;
            a = $urandom & 32'h0000_303C;
            b = $urandom & 32'h0000_303C;
            step($urandom % 2, a, ($urandom % 3) != 0, b, $urandom % 2,
                 12'($urandom % 16), ($urandom % 5) == 0, "R2 R3 R4 R6 R9 rand");
        end
        finish_run();
    end
endmodule